// File: doc/BRIEF.md
# Shared-Strobe Multi-Converter Read Sequencer

This block sits on the host side of a group of 14-bit serial converters. The converters share one convert strobe, one serial clock and one data return line, and each has its own active-low select. A single start request runs one full cycle. The strobe rises while every select is held high, which places the converters in chip-select mode. The block then waits out the worst-case conversion time. After that it reads the converters one at a time, lowest index first, clocking in each result with the most significant bit first.

Each result leaves the block with its converter index and a one-cycle valid pulse. After the last converter has been read, the strobe drops and a done pulse is given. The strobe is then held low for a minimum recovery time, and only after that is a new start accepted. All timing is set in system clock cycles through parameters.

Top module: `cs_multi_reader`

## Requirements
- R1: With the block idle and `start_i` high at a clock edge, `cnv_o` goes high in the next cycle while every bit of `sel_n_o` is 1. A start request seen while a cycle is in progress is ignored.
- R2: No select goes low until `cnv_o` has been high, with all selects high, for exactly `CONV_CYC` cycles. `cnv_o` stays high while any select is low.
- R3: Converters are selected one after another in ascending index order, starting at 0. At most one bit of `sel_n_o` is 0 at any time, and all selects stay high for `HALF_CYC` cycles between two reads.
- R4: Each read produces exactly `WORD_W` rising and `WORD_W` falling edges on `sclk_o`, each high phase lasting `HALF_CYC` cycles. `sclk_o` is low whenever no converter is selected.
- R5: `sdo_i` is sampled at each falling edge of `sclk_o`, using the value present just before that edge. The first sample is the most significant bit. `word_vld_o` is a one-cycle pulse that comes in the cycle in which the last falling edge appears and the select returns high. In that cycle `word_o` holds the full word and `word_idx_o` holds the converter index.
- R6: `done_o` pulses once per cycle, in the same cycle as the last converter's `word_vld_o`. In that same cycle `cnv_o` falls.
- R7: After it falls, `cnv_o` stays low for at least `HOLD_CYC`+1 cycles, and start requests during the first `HOLD_CYC` of them are ignored. When `start_i` is held high, the next rise comes after exactly `HOLD_CYC`+1 low cycles.
- R8: During and right after reset, `cnv_o`, `sclk_o`, `word_vld_o` and `done_o` are 0 and every bit of `sel_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to run one convert-and-read cycle |
| sdo_i | input | 1 | Shared serial data from the converters |
| cnv_o | output | 1 | Shared convert strobe |
| sclk_o | output | 1 | Shared serial clock, idles low |
| sel_n_o | output | N_CONV | Per-converter active-low select |
| word_o | output | WORD_W | Captured result |
| word_idx_o | output | IDX_W | Index of the converter that produced `word_o` |
| word_vld_o | output | 1 | One-cycle valid for `word_o` |
| done_o | output | 1 | One-cycle pulse at the end of the cycle |

## Verification
The final capture falls in the same cycle as three other events: the end-of-cycle signalling, the strobe dropping, and the last select returning high. The bench runs full cycles with distinct bit patterns and checks that the single done pulse coincides with the last valid pulse while the strobe is low. It also applies a start pulse in exactly that done cycle and another in the middle of a read, then confirms that only one strobe rise occurs. A second case holds start high across two cycles and measures the exact low time of the strobe between them.

// File: rtl/cs_rd_pkg.sv
package cs_rd_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CONV,
      ST_SETUP,
      ST_HI,
      ST_LO,
      ST_GAP,
      ST_HOLD
   } rd_state_e;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/cs_rd_timer.sv
module cs_rd_timer #(
   parameter int TW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [TW-1:0] val_i,
   output logic          zero_o
);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/cs_rd_shifter.sv
module cs_rd_shifter #(
   parameter int W = 14
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         shift_i,
   input  logic         bit_i,
   output logic [W-1:0] word_next_o,
   output logic         last_o
);

   localparam int CW = $clog2(W + 1);

   logic [W-2:0] sr_q;
   logic [CW-1:0] cnt_q;

   assign word_next_o = {sr_q, bit_i};
   assign last_o      = (cnt_q == CW'(W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q  <= '0;
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (shift_i) begin
         sr_q  <= word_next_o[W-2:0];
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R4: never more than W bits taken per selection
   p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(W));

endmodule

// File: rtl/cs_rd_selgen.sv
module cs_rd_selgen #(
   parameter int N     = 2,
   parameter int IDX_W = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_i,
   input  logic [IDX_W-1:0] set_idx_i,
   input  logic             clr_i,
   output logic [N-1:0]     sel_n_o
);

   for (genvar g = 0; g < N; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sel_n_o[g] <= 1'b1;
         end else if (clr_i) begin
            sel_n_o[g] <= 1'b1;
         end else if (set_i && (set_idx_i == IDX_W'(g))) begin
            sel_n_o[g] <= 1'b0;
         end
      end
   end

   // R3: at most one converter drives the shared line
   p_one_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~sel_n_o) <= 1);

endmodule

// File: rtl/cs_multi_reader.sv
module cs_multi_reader
   import cs_rd_pkg::*;
#(
   parameter int N_CONV   = 2,
   parameter int WORD_W   = 14,
   parameter int CONV_CYC = 200,
   parameter int HALF_CYC = 2,
   parameter int HOLD_CYC = 8,
   localparam int IDX_W   = (N_CONV > 1) ? $clog2(N_CONV) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              sdo_i,
   output logic              cnv_o,
   output logic              sclk_o,
   output logic [N_CONV-1:0] sel_n_o,
   output logic [WORD_W-1:0] word_o,
   output logic [IDX_W-1:0]  word_idx_o,
   output logic              word_vld_o,
   output logic              done_o
);

   localparam int TMAX = max3(CONV_CYC, HALF_CYC, HOLD_CYC);
   localparam int TW   = $clog2(TMAX + 1);

   if (N_CONV < 2) begin : g_bad_n
      $error("N_CONV must be at least 2");
   end
   if (WORD_W < 3) begin : g_bad_w
      $error("WORD_W must be at least 3");
   end
   if (CONV_CYC < 1 || HALF_CYC < 1 || HOLD_CYC < 1) begin : g_bad_t
      $error("timing parameters must be at least 1");
   end

   rd_state_e        state_q;
   logic [IDX_W-1:0] idx_q;
   logic             tz;
   logic             tmr_load;
   logic [TW-1:0]    tmr_val;
   logic             sel_set, sel_clr;
   logic             sh_clr, sh_en, sh_last;
   logic [WORD_W-1:0] sh_word;
   logic             last_conv;

   assign last_conv = (idx_q == IDX_W'(N_CONV - 1));

   cs_rd_timer #(.TW(TW)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (tmr_load),
      .val_i  (tmr_val),
      .zero_o (tz)
   );

   cs_rd_shifter #(.W(WORD_W)) u_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_i       (sh_clr),
      .shift_i     (sh_en),
      .bit_i       (sdo_i),
      .word_next_o (sh_word),
      .last_o      (sh_last)
   );

   cs_rd_selgen #(.N(N_CONV), .IDX_W(IDX_W)) u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (sel_set),
      .set_idx_i (idx_q),
      .clr_i     (sel_clr),
      .sel_n_o   (sel_n_o)
   );

   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = '0;
      sel_set  = 1'b0;
      sel_clr  = 1'b0;
      sh_clr   = 1'b0;
      sh_en    = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start_i) begin
               tmr_load = 1'b1;
               tmr_val  = TW'(CONV_CYC - 1);
            end
         end
         ST_CONV, ST_GAP: begin
            if (tz) begin
               sel_set  = 1'b1;
               sh_clr   = 1'b1;
               tmr_load = 1'b1;
               tmr_val  = TW'(HALF_CYC - 1);
            end
         end
         ST_SETUP, ST_LO: begin
            if (tz) begin
               tmr_load = 1'b1;
               tmr_val  = TW'(HALF_CYC - 1);
            end
         end
         ST_HI: begin
            if (tz) begin
               sh_en    = 1'b1;
               tmr_load = 1'b1;
               tmr_val  = (sh_last && last_conv) ? TW'(HOLD_CYC - 1)
                                                 : TW'(HALF_CYC - 1);
               sel_clr  = sh_last;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         idx_q      <= '0;
         cnv_o      <= 1'b0;
         sclk_o     <= 1'b0;
         word_o     <= '0;
         word_idx_o <= '0;
         word_vld_o <= 1'b0;
         done_o     <= 1'b0;
      end else begin
         word_vld_o <= 1'b0;
         done_o     <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  cnv_o   <= 1'b1;
                  idx_q   <= '0;
                  state_q <= ST_CONV;
               end
            end
            ST_CONV: if (tz) state_q <= ST_SETUP;
            ST_SETUP, ST_LO: begin
               if (tz) begin
                  sclk_o  <= 1'b1;
                  state_q <= ST_HI;
               end
            end
            ST_HI: begin
               if (tz) begin
                  sclk_o <= 1'b0;
                  if (sh_last) begin
                     word_o     <= sh_word;
                     word_idx_o <= idx_q;
                     word_vld_o <= 1'b1;
                     if (last_conv) begin
                        cnv_o   <= 1'b0;
                        done_o  <= 1'b1;
                        state_q <= ST_HOLD;
                     end else begin
                        idx_q   <= idx_q + 1'b1;
                        state_q <= ST_GAP;
                     end
                  end else begin
                     state_q <= ST_LO;
                  end
               end
            end
            ST_GAP:  if (tz) state_q <= ST_SETUP;
            ST_HOLD: if (tz) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R1: strobe only rises with every select high
   p_rise_all_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cnv_o) |-> (&sel_n_o));

   // R2: a converter is selected only while the strobe is high
   p_sel_in_cnv_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(&sel_n_o) |-> cnv_o);

   // R4: serial clock rests low with nobody selected
   p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (&sel_n_o) |-> !sclk_o);

   // R5: valid is a single-cycle pulse
   p_vld_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld_o |=> !word_vld_o);

   // R6: done coincides with the last word and the strobe fall
   p_done_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (word_vld_o && !cnv_o && word_idx_o == IDX_W'(N_CONV - 1)));

   // R7: strobe low through the recovery window
   p_hold_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HOLD) |-> !cnv_o);

endmodule

// File: tb/cs_multi_reader_tb.sv
module cs_multi_reader_tb;

   localparam int CLK_PERIOD = 10;
   localparam int N    = 3;
   localparam int W    = 14;
   localparam int CONV = 20;
   localparam int HALF = 2;
   localparam int HOLD = 6;
   localparam int IW   = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic sdo;
   logic cnv, sclk, vld, done;
   logic [N-1:0] sel_n;
   logic [W-1:0] word;
   logic [IW-1:0] widx;

   always #(CLK_PERIOD / 2) clk = ~clk;

   cs_multi_reader #(
      .N_CONV(N), .WORD_W(W), .CONV_CYC(CONV), .HALF_CYC(HALF), .HOLD_CYC(HOLD)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .sdo_i(sdo),
      .cnv_o(cnv), .sclk_o(sclk), .sel_n_o(sel_n), .word_o(word),
      .word_idx_o(widx), .word_vld_o(vld), .done_o(done)
   );

   // converter models
   logic [W-1:0] dev_word [N];
   int dev_bit [N];
   logic m_psclk = 1'b0;

   always @(sclk or sel_n) begin
      for (int i = 0; i < N; i++) begin
         if (sel_n[i]) dev_bit[i] = 0;
         else if (!sclk && m_psclk) dev_bit[i] = dev_bit[i] + 1;
      end
      m_psclk = sclk;
   end

   always_comb begin
      sdo = 1'b0;
      for (int i = 0; i < N; i++)
         if (!sel_n[i] && dev_bit[i] < W) sdo = dev_word[i][W-1-dev_bit[i]];
   end

   // monitor
   logic mon_clr = 1'b0;
   logic p_cnv = 1'b0, p_sclk = 1'b0, waiting = 1'b0;
   logic [N-1:0] p_sel = '1;
   int n_rise, rise_bad, wait_cnt, wait_meas, low_run, low_meas;
   int multi, selnocnv, nsel, s_rise, s_fall, s_hi, idle_err, vc, dc, done_err;
   int seq [8];
   logic [W-1:0] got_word [8];
   logic [IW-1:0] got_idx [8];

   always @(negedge clk) begin
      if (mon_clr) begin
         n_rise = 0; rise_bad = 0; wait_cnt = 0; wait_meas = -1; low_meas = -1;
         multi = 0; selnocnv = 0; nsel = 0; s_rise = 0; s_fall = 0; s_hi = 0;
         idle_err = 0; vc = 0; dc = 0; done_err = 0; waiting = 1'b0;
      end else begin
         if (cnv && !p_cnv) begin
            n_rise++;
            if (!(&sel_n)) rise_bad++;
            wait_cnt = 0; waiting = 1'b1; low_meas = low_run;
         end
         if (!cnv) low_run++; else low_run = 0;
         if (waiting && cnv && (&sel_n)) wait_cnt++;
         if (waiting && !(&sel_n)) begin waiting = 1'b0; wait_meas = wait_cnt; end
         if ($countones(~sel_n) > 1) multi++;
         if (!(&sel_n) && !cnv) selnocnv++;
         for (int i = 0; i < N; i++)
            if (!sel_n[i] && p_sel[i]) begin
               if (nsel < 8) seq[nsel] = i;
               nsel++;
            end
         if (sclk && !p_sclk) s_rise++;
         if (!sclk && p_sclk) s_fall++;
         if (sclk) s_hi++;
         if (sclk && (&sel_n)) idle_err++;
         if (vld) begin
            if (vc < 8) begin got_word[vc] = word; got_idx[vc] = widx; end
            vc++;
         end
         if (done) begin
            dc++;
            if (!vld || cnv) done_err++;
         end
      end
      p_cnv = cnv; p_sclk = sclk; p_sel = sel_n;
   end

   int checks = 0;
   int failures = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_mon();
      @(negedge clk) mon_clr = 1'b1;
      @(negedge clk) mon_clr = 1'b0;
   endtask

   task automatic pulse_start();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
   endtask

   task automatic t_reset();
      // R8: reset values
      chk(cnv == 1'b0, "R8 cnv", int'(cnv), 0);
      chk(sclk == 1'b0, "R8 sclk", int'(sclk), 0);
      chk(sel_n == '1, "R8 sel_n", int'(sel_n), (1 << N) - 1);
      chk(vld == 1'b0 && done == 1'b0, "R8 vld/done", int'({vld, done}), 0);
   endtask

   task automatic t_pattern(input logic [W-1:0] a, input logic [W-1:0] b,
                            input logic [W-1:0] c);
      dev_word[0] = a; dev_word[1] = b; dev_word[2] = c;
      clear_mon();
      pulse_start();
      while (dc < 1) @(negedge clk);
      repeat (2) @(negedge clk);
      chk(rise_bad == 0 && n_rise == 1, "R1 single rise, selects high", rise_bad, 0);
      chk(wait_meas == CONV, "R2 conversion wait", wait_meas, CONV);
      chk(selnocnv == 0, "R2 select without strobe", selnocnv, 0);
      chk(multi == 0, "R3 overlapping selects", multi, 0);
      chk(nsel == N, "R3 selection count", nsel, N);
      for (int i = 0; i < N; i++)
         chk(seq[i] == i, "R3 selection order", seq[i], i);
      chk(s_rise == N * W, "R4 sclk rising edges", s_rise, N * W);
      chk(s_fall == N * W, "R4 sclk falling edges", s_fall, N * W);
      chk(s_hi == N * W * HALF, "R4 sclk high cycles", s_hi, N * W * HALF);
      chk(idle_err == 0, "R4 sclk high while idle", idle_err, 0);
      chk(vc == N, "R5 word count", vc, N);
      for (int i = 0; i < N; i++) begin
         chk(got_word[i] == dev_word[i], "R5 word value", int'(got_word[i]), int'(dev_word[i]));
         chk(got_idx[i] == IW'(i), "R5 word index", int'(got_idx[i]), i);
      end
      chk(dc == 1 && done_err == 0, "R6 done with last word, strobe low", done_err, 0);
      repeat (HOLD + 2) @(negedge clk);
   endtask

   task automatic t_ignore();
      dev_word[0] = 14'h0F0F; dev_word[1] = 14'h30C3; dev_word[2] = 14'h0001;
      clear_mon();
      pulse_start();
      while (&sel_n) @(negedge clk);
      pulse_start();                   // R1: mid-read start ignored
      while (!done) @(negedge clk);
      start = 1'b1;                    // R7: start in done cycle ignored
      @(negedge clk) start = 1'b0;
      repeat (3 * HOLD) @(negedge clk);
      chk(n_rise == 1, "R1/R7 ignored start requests", n_rise, 1);
      chk(cnv == 1'b0, "R7 strobe still low", int'(cnv), 0);
      chk(vc == N && got_word[1] == 14'h30C3, "R5 word during ignore test",
          int'(got_word[1]), 14'h30C3);
   endtask

   task automatic t_back2back();
      dev_word[0] = 14'h1234; dev_word[1] = 14'h2BCD; dev_word[2] = 14'h3E01;
      clear_mon();
      @(negedge clk) start = 1'b1;
      while (dc < 2) @(negedge clk);
      start = 1'b0;
      repeat (3 * HOLD) @(negedge clk);
      chk(n_rise == 2, "R7 back-to-back rises", n_rise, 2);
      chk(low_meas == HOLD + 1, "R7 strobe low time", low_meas, HOLD + 1);
      chk(vc == 2 * N && got_word[5] == 14'h3E01, "R5 second cycle word",
          int'(got_word[5]), 14'h3E01);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int i = 0; i < N; i++) dev_word[i] = '0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_pattern(14'h2A5C, 14'h15A3, 14'h3FFF);
      t_pattern(14'h0000, 14'h2001, 14'h1FFE);
      t_ignore();
      t_back2back();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule